// File: doc/BRIEF.md
# Fixed-Point Radix-2 Butterfly

This block is the arithmetic heart of an iterative radix-2 decimation-in-time transform engine. Each time its strobe is raised it accepts two complex samples, A and B, plus a complex twiddle factor. After the next rising clock edge it presents the pair A + W·B and A − W·B. A sequencer outside the block chooses which samples and which twiddle to feed in and writes the results back. This block only does the math.

Every complex value travels as one packed word. The real half sits in the upper half of the word and the imaginary half in the lower half. Each half is a signed fraction with one integer bit. Four compile-time switches shape the datapath, which otherwise stays the same:
- halving each result per stage,
- round-half-up or plain truncation for that halving,
- clamping or two's-complement wraparound on overflow,
- forward or conjugated (inverse) twiddles.

A dedicated input marks the trivial twiddle of exactly +1. That value cannot be written as a fraction of this format, so the marked case skips the multiplier.

The output register is governed by a two-state machine. `BF_EMPTY` means no fresh result is present, and `BF_LOADED` means the outputs hold a result captured on the last edge. There are two transitions from any state. A raised strobe (capture) leads to `BF_LOADED`. A low strobe (drain) leads to `BF_EMPTY`.

Top module: `bfly_radix2`

## Requirements
- R1: Samples `a_i`, `b_i`, `x_o` and `y_o` are each 2·DW bits wide. The signed real part is in bits [2·DW−1:DW] and the signed imaginary part is in bits [DW−1:0]; with DW=16 that is real in [31:16] and imaginary in [15:0].
- R2: With `tw_unity_i` low and INVERSE=0, the twiddle is W = cos − j·sin, with `tw_cos_i` and `tw_sin_i` as signed TW-bit fractions (TW−1 fraction bits). The full-precision products give re = Br·Wr − Bi·Wi and im = Br·Wi + Bi·Wr. Each is shifted arithmetically right by TW−1 bits, truncating, and then narrowed to DW bits using the overflow policy of R8.
- R3: With INVERSE=1, the twiddle is W = cos + j·sin; all other rules are unchanged.
- R4: With `tw_unity_i` high, W·B equals B exactly, and `tw_cos_i` and `tw_sin_i` have no effect.
- R5: The sum x = A + W·B and the difference y = A − W·B are formed per component with one guard bit, as DW+1-bit values.
- R6: With SCALE=1 and ROUND=0, each output component is its DW+1-bit sum or difference shifted arithmetically right by one, which truncates toward minus infinity.
- R7: With SCALE=1 and ROUND=1, one is added before the shift, so exact halves round upward. With SCALE=0, ROUND has no effect.
- R8: With SCALE=0, SAT=0 keeps the low DW bits of an out-of-range value. SAT=1 clamps it to 0x7FFF or 0x8000 for DW=16. The same policy narrows the twiddle product.
- R9: When `in_valid_i` is high at a rising edge, `x_o` and `y_o` take the new results at that edge. `out_valid_o` is high for the following cycle (state `BF_LOADED`).
- R10: When `in_valid_i` is low at a rising edge, `x_o` and `y_o` keep their values and `out_valid_o` is low in the following cycle (state `BF_EMPTY`).
- R11: While `rst_ni` is low, `out_valid_o`, `x_o` and `y_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Strobe: capture a new butterfly this edge |
| a_i | input | 2*DW | Packed complex sample A |
| b_i | input | 2*DW | Packed complex sample B |
| tw_cos_i | input | TW | Twiddle cosine, signed fraction |
| tw_sin_i | input | TW | Twiddle sine, signed fraction |
| tw_unity_i | input | 1 | Twiddle is exactly +1; bypass the multiplier |
| out_valid_o | output | 1 | A fresh result is on x_o and y_o |
| x_o | output | 2*DW | Packed A + W·B |
| y_o | output | 2*DW | Packed A − W·B |

## Verification
The bench drives all sixteen switch combinations side by side and aims at the values where fixed-point butterflies usually break.

- **Sums at or near full scale.** A design without the guard bit, or with a misplaced clamp, returns a wrapped sign instead of the clamped or correctly halved value.
- **A sine of 0x8000.** Negating it in only DW bits overflows back to itself, which flips the sign of the rotated term.
- **Sums of +1 and −1.** Truncation and round-half-up disagree here, so swapping them or rounding toward zero is visible.
- **Unity twiddles paired with junk cos/sin values.** These show whether the bypass really ignores the twiddle inputs.
- **Quarter-turn twiddles.** These separate the forward conjugation from the inverse one.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Output register occupancy.
    typedef enum logic {
        BF_EMPTY  = 1'b0,
        BF_LOADED = 1'b1
    } bf_state_e;

    // Number of scalar result lanes: x real, x imag, y real, y imag.
    localparam int unsigned NUM_LANES = 4;

endpackage

// File: rtl/bfly_twiddle_mul.sv
module bfly_twiddle_mul #(
    parameter int DW      = 16,
    parameter int TW      = 16,
    parameter bit SAT     = 1'b0,
    parameter bit INVERSE = 1'b0
) (
    input  logic signed [DW-1:0] b_re_i,
    input  logic signed [DW-1:0] b_im_i,
    input  logic signed [TW-1:0] cos_i,
    input  logic signed [TW-1:0] sin_i,
    input  logic                 unity_i,
    output logic signed [DW-1:0] t_re_o,
    output logic signed [DW-1:0] t_im_o
);

    localparam int PW = DW + TW + 2;
    localparam int SH = TW - 1;
    localparam logic signed [PW-1:0] MAXV = PW'(2 ** (DW - 1) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [TW:0]   w_re;
    logic signed [TW:0]   w_im;
    logic signed [PW-1:0] p_re;
    logic signed [PW-1:0] p_im;
    logic signed [PW-1:0] q_re;
    logic signed [PW-1:0] q_im;

    // Bring a wide product back to DW bits under the overflow policy.
    function automatic logic signed [DW-1:0] narrow(input logic signed [PW-1:0] v);
        if (SAT && (v > MAXV)) begin
            return MAXV[DW-1:0];
        end else if (SAT && (v < MINV)) begin
            return MINV[DW-1:0];
        end
        return v[DW-1:0];
    endfunction

    always_comb begin
        // One extra bit so that negating the most negative sine is exact.
        w_re = (TW+1)'(cos_i);
        w_im = INVERSE ? (TW+1)'(sin_i) : -((TW+1)'(sin_i));
        p_re = PW'(b_re_i) * PW'(w_re) - PW'(b_im_i) * PW'(w_im);
        p_im = PW'(b_re_i) * PW'(w_im) + PW'(b_im_i) * PW'(w_re);
        q_re = p_re >>> SH;
        q_im = p_im >>> SH;
        if (unity_i) begin
            t_re_o = b_re_i;
            t_im_o = b_im_i;
        end else begin
            t_re_o = narrow(q_re);
            t_im_o = narrow(q_im);
        end
    end

endmodule

// File: rtl/bfly_lane_post.sv
module bfly_lane_post #(
    parameter int DW    = 16,
    parameter bit SCALE = 1'b1,
    parameter bit ROUND = 1'b0,
    parameter bit SAT   = 1'b0
) (
    input  logic signed [DW:0]   s_i,
    output logic signed [DW-1:0] y_o
);

    localparam logic signed [DW:0]   HALF  = (SCALE && ROUND) ? (DW+1)'(1) : '0;
    localparam bit                   CLAMP = SAT && !SCALE;
    localparam logic signed [DW-1:0] LMAX  = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] LMIN  = {1'b1, {(DW-1){1'b0}}};

    logic overflow;

    always_comb begin
        // The guard bit disagrees with the DW-bit sign only when out of range.
        overflow = s_i[DW] != s_i[DW-1];
        if (SCALE) begin
            y_o = DW'((s_i + HALF) >>> 1);
        end else if (CLAMP && overflow) begin
            y_o = s_i[DW] ? LMIN : LMAX;
        end else begin
            y_o = s_i[DW-1:0];
        end
    end

endmodule

// File: rtl/bfly_radix2.sv
module bfly_radix2 #(
    parameter int DW      = 16,
    parameter int TW      = 16,
    parameter bit SCALE   = 1'b1,
    parameter bit ROUND   = 1'b0,
    parameter bit SAT     = 1'b0,
    parameter bit INVERSE = 1'b0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            in_valid_i,
    input  logic [2*DW-1:0] a_i,
    input  logic [2*DW-1:0] b_i,
    input  logic [TW-1:0]   tw_cos_i,
    input  logic [TW-1:0]   tw_sin_i,
    input  logic            tw_unity_i,
    output logic            out_valid_o,
    output logic [2*DW-1:0] x_o,
    output logic [2*DW-1:0] y_o
);

    import bfly_pkg::*;

    localparam int SW = 2 * DW;

    bf_state_e state_q, state_d;

    logic signed [DW-1:0] a_re, a_im, b_re, b_im;
    logic signed [DW-1:0] t_re, t_im;
    logic signed [DW:0]   pre  [NUM_LANES];
    logic signed [DW-1:0] post [NUM_LANES];
    logic [SW-1:0]        x_q, y_q;

    assign a_re = a_i[SW-1:DW];
    assign a_im = a_i[DW-1:0];
    assign b_re = b_i[SW-1:DW];
    assign b_im = b_i[DW-1:0];

    bfly_twiddle_mul #(
        .DW(DW), .TW(TW), .SAT(SAT), .INVERSE(INVERSE)
    ) u_mul (
        .b_re_i (b_re),
        .b_im_i (b_im),
        .cos_i  (tw_cos_i),
        .sin_i  (tw_sin_i),
        .unity_i(tw_unity_i),
        .t_re_o (t_re),
        .t_im_o (t_im)
    );

    // Guard-bit sum and difference, lane order: x re, x im, y re, y im.
    always_comb begin
        pre[0] = (DW+1)'(a_re) + (DW+1)'(t_re);
        pre[1] = (DW+1)'(a_im) + (DW+1)'(t_im);
        pre[2] = (DW+1)'(a_re) - (DW+1)'(t_re);
        pre[3] = (DW+1)'(a_im) - (DW+1)'(t_im);
    end

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        bfly_lane_post #(
            .DW(DW), .SCALE(SCALE), .ROUND(ROUND), .SAT(SAT)
        ) u_post (
            .s_i(pre[k]),
            .y_o(post[k])
        );
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BF_EMPTY:  state_d = in_valid_i ? BF_LOADED : BF_EMPTY;
            BF_LOADED: state_d = in_valid_i ? BF_LOADED : BF_EMPTY;
            default:   state_d = BF_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= BF_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Result register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            x_q <= '0;
            y_q <= '0;
        end else if (in_valid_i) begin
            x_q <= {post[0], post[1]};
            y_q <= {post[2], post[3]};
        end
    end

    assign out_valid_o = (state_q == BF_LOADED);
    assign x_o         = x_q;
    assign y_o         = y_q;

endmodule

// File: rtl/bfly_radix2_chk.sv
module bfly_radix2_chk #(
    parameter int DW    = 16,
    parameter bit SCALE = 1'b1,
    parameter bit ROUND = 1'b0,
    parameter bit SAT   = 1'b0
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            in_valid_i,
    input logic            tw_unity_i,
    input logic [2*DW-1:0] a_i,
    input logic [2*DW-1:0] b_i,
    input logic            out_valid_o,
    input logic [2*DW-1:0] x_o,
    input logic [2*DW-1:0] y_o
);

    localparam logic [DW-1:0] CMAX = {1'b0, {(DW-1){1'b1}}};

    logic [DW-1:0] a_re, b_re, a_im, b_im, x_re, y_im;
    assign a_re = a_i[2*DW-1:DW];
    assign b_re = b_i[2*DW-1:DW];
    assign a_im = a_i[DW-1:0];
    assign b_im = b_i[DW-1:0];
    assign x_re = x_o[2*DW-1:DW];
    assign y_im = y_o[DW-1:0];

    p_valid_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);

    p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> (!out_valid_o && $stable(x_o) && $stable(y_o)));

    p_reset_clear_r11: assert property (@(posedge clk_i)
        !rst_ni |=> (!out_valid_o && x_o == '0 && y_o == '0));

    if (!SCALE && !SAT) begin : g_wrap
        p_unity_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (in_valid_i && tw_unity_i) |=>
            (x_re == DW'($past(a_re) + $past(b_re)) &&
             y_im == DW'($past(a_im) - $past(b_im))));
    end

    if (SCALE && !ROUND) begin : g_half
        p_unity_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (in_valid_i && tw_unity_i) |=>
            (x_re == DW'(($signed({$past(a_re[DW-1]), $past(a_re)}) +
                          $signed({$past(b_re[DW-1]), $past(b_re)})) >>> 1)));
    end

    if (SAT && !SCALE) begin : g_clamp
        p_clamp_top_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (in_valid_i && tw_unity_i && a_re == CMAX && b_re == CMAX) |=>
            (x_re == CMAX));
    end

endmodule

bind bfly_radix2 bfly_radix2_chk #(
    .DW(DW), .SCALE(SCALE), .ROUND(ROUND), .SAT(SAT)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .tw_unity_i (tw_unity_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .out_valid_o(out_valid_o),
    .x_o        (x_o),
    .y_o        (y_o)
);

// File: tb/bfly_radix2_tb_top.sv
module bfly_radix2_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NCFG       = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic [15:0] tc = '0, ts = '0;
    logic        unity = 1'b0;

    logic        v_arr [NCFG];
    logic [31:0] x_arr [NCFG];
    logic [31:0] y_arr [NCFG];
    logic [31:0] x_prev [NCFG];
    logic [31:0] y_prev [NCFG];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Config index bits: 0 scale, 1 round, 2 saturate, 3 inverse.
    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
        bfly_radix2 #(
            .DW(16), .TW(16),
            .SCALE  (bit'(k & 1)),
            .ROUND  (bit'((k >> 1) & 1)),
            .SAT    (bit'((k >> 2) & 1)),
            .INVERSE(bit'((k >> 3) & 1))
        ) dut_i (
            .clk_i      (clk),
            .rst_ni     (rst_n),
            .in_valid_i (in_valid),
            .a_i        (a),
            .b_i        (b),
            .tw_cos_i   (tc),
            .tw_sin_i   (ts),
            .tw_unity_i (unity),
            .out_valid_o(v_arr[k]),
            .x_o        (x_arr[k]),
            .y_o        (y_arr[k])
        );
    end

    function automatic longint sx16(input logic [15:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint fit16(input longint v, input bit sat);
        logic [63:0] t;
        if (sat && v > 32767) return 32767;
        if (sat && v < -32768) return -32768;
        t = v;
        return sx16(t[15:0]);
    endfunction

    function automatic longint lane(input longint s, input bit sc, input bit rd, input bit st);
        if (sc) return (s + (rd ? 1 : 0)) >>> 1;
        return fit16(s, st);
    endfunction

    task automatic model(input int cfg, output logic [31:0] ex, output logic [31:0] ey);
        bit sc = cfg[0], rd = cfg[1], st = cfg[2], iv = cfg[3];
        longint ar = sx16(a[31:16]), ai = sx16(a[15:0]);
        longint br = sx16(b[31:16]), bi = sx16(b[15:0]);
        longint wr = sx16(tc), wi = iv ? sx16(ts) : -sx16(ts);
        longint tr, ti;
        logic [63:0] r0, r1, r2, r3;
        if (unity) begin
            tr = br;
            ti = bi;
        end else begin
            tr = fit16((br * wr - bi * wi) >>> 15, st);
            ti = fit16((br * wi + bi * wr) >>> 15, st);
        end
        r0 = lane(ar + tr, sc, rd, st);
        r1 = lane(ai + ti, sc, rd, st);
        r2 = lane(ar - tr, sc, rd, st);
        r3 = lane(ai - ti, sc, rd, st);
        ex = {r0[15:0], r1[15:0]};
        ey = {r2[15:0], r3[15:0]};
    endtask

    task automatic check32(input string tag, input int cfg, input logic [31:0] act,
                           input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cfg=%0d actual=%08h expected=%08h", tag, cfg, act, exp);
        end
    endtask

    // Drive one butterfly, wait past the capturing edge, compare every config.
    task automatic apply(input string tag, input logic [31:0] va, input logic [31:0] vb,
                         input logic [15:0] vc, input logic [15:0] vs, input logic vu);
        logic [31:0] ex, ey;
        in_valid = 1'b1;
        a = va; b = vb; tc = vc; ts = vs; unity = vu;
        @(negedge clk);
        for (int k = 0; k < NCFG; k++) begin
            model(k, ex, ey);
            check32({tag, " x"}, k, x_arr[k], ex);
            check32({tag, " y"}, k, y_arr[k], ey);
            check32("R9 valid", k, {31'd0, v_arr[k]}, 32'd1);
            x_prev[k] = x_arr[k];
            y_prev[k] = y_arr[k];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd24681);
        repeat (3) @(negedge clk);
        for (int k = 0; k < NCFG; k++) begin
            check32("R11 reset valid", k, {31'd0, v_arr[k]}, 32'd0);
            check32("R11 reset x", k, x_arr[k], 32'd0);
            check32("R11 reset y", k, y_arr[k], 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        apply("R1 R5 packing", 32'h0123_0456, 32'h0010_FFF0, 16'h0, 16'h0, 1'b1);
        apply("R8 R6 full-scale sum", 32'h7FFF_7FFF, 32'h7FFF_7FFF, 16'h0, 16'h0, 1'b1);
        apply("R8 R5 full-scale diff", 32'h8000_8000, 32'h7FFF_8000, 16'h0, 16'h0, 1'b1);
        apply("R7 R6 round plus one", 32'h0001_FFFF, 32'h0000_0000, 16'h0, 16'h0, 1'b1);
        apply("R4 unity ignores twiddle", 32'h1111_2222, 32'h8000_7FFF, 16'h1234, 16'h8000, 1'b1);
        apply("R2 R8 negative sine", 32'h0000_0000, 32'h8000_8000, 16'h7FFF, 16'h8000, 1'b0);
        apply("R3 quarter turn", 32'h0100_0200, 32'h4000_0000, 16'h0000, 16'h7FFF, 1'b0);
        apply("R2 half angle", 32'h2000_E000, 32'h3000_5000, 16'h5A82, 16'h5A82, 1'b0);

        // R10: strobe low with new data must leave outputs untouched.
        in_valid = 1'b0;
        a = 32'hDEAD_BEEF; b = 32'h1357_9BDF; unity = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NCFG; k++) begin
            check32("R10 hold valid", k, {31'd0, v_arr[k]}, 32'd0);
            check32("R10 hold x", k, x_arr[k], x_prev[k]);
            check32("R10 hold y", k, y_arr[k], y_prev[k]);
        end

        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra, rb;
            logic [15:0] rc, rs;
            ra = $urandom;
            rb = $urandom;
            rc = $urandom;
            rs = $urandom;
            if (n % 7 == 0) ra = {16'h7FFF, ra[15:0]};
            if (n % 11 == 0) rb = {rb[31:16], 16'h8000};
            if (n % 13 == 0) rs = 16'h8000;
            apply("R2 R3 R5 R6 R7 R8 random", ra, rb, rc, rs, (n % 5) == 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule